// File: doc/BRIEF.md
# Indexed Address and Branch Page-Cross Unit

This unit forms effective addresses for an 8-bit processor with a 16-bit address bus. On a start strobe it takes a fetched base address, an index value, a signed branch offset, the program counter and a branch-taken flag. It produces a partial address, which is the first bus address to use, and a final corrected address. When the low-byte sum spills into a neighbouring page, the unit holds a pending carry of +1 or -1 and raises an extra-cycle request. The high byte is corrected one cycle later, on the fix-up cycle.

The instruction sequencer uses the partial address for the dummy access of a page-crossing cycle and the final address for the real access. It uses `hold_next` to hold off the start of the next instruction while a taken branch is still repairing its high byte. Memory fetches and step sequencing are outside this block.

Top module: `idx_addr_unit`

## Requirements
- R1: After reset, `addr_part`, `addr_fix`, `st_data` and `carry_pend` are zero, and `extra_req`, `hold_next` and `done` are low.
- R2: Absolute indexed mode (`mode`=2'b00). `addr_part` is {base_hi, (base_lo+index) mod 256}. When base_lo+index exceeds 255, `carry_pend` is 2'b01 and `extra_req` is high for one cycle. On the following edge `addr_fix` becomes {(base_hi+1) mod 256, low sum} and `done` pulses.
- R3: An accepted operation that needs no fix-up presents `done` high and `extra_req` low in the cycle after the start edge. In that cycle `addr_fix` already holds its final value, and `done` is never high together with `extra_req`.
- R4: Zero-page indexed mode (`mode`=2'b01). Both addresses are {8'h00, (base_lo+index) mod 256}, and the mode never requests an extra cycle.
- R5: Branch mode (`mode`=2'b10) with `taken` low. Both addresses equal `pc`, and no extra cycle is requested.
- R6: A taken branch whose target pc+sign-extended(disp) stays in the page of `pc` requests exactly one extra cycle. Then `addr_fix` equals the target and `carry_pend` stays 2'b00.
- R7: A taken branch that crosses a page requests two extra cycles, and `hold_next` is high for both. `addr_part` is {pc high byte, target low byte}. `carry_pend` is 2'b01 for a forward offset and 2'b11 for a backward one. `addr_fix` then equals the target.
- R8: On the edge that ends the fix-up, `carry_pend` returns to 2'b00 and `hold_next` drops.
- R9: Masked-store mode (`mode`=2'b11). `addr_fix` is {base_hi AND index, (base_lo+index) mod 256}, and `st_data` is index AND ((base_hi+1) mod 256). An extra cycle is requested only when the low sum carries.
- R10: A start strobe that arrives while `extra_req` is high is ignored. `addr_part` and the pending operation's `addr_fix` are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accept a new address operation |
| mode | input | 2 | 00 abs indexed, 01 zero-page indexed, 10 branch, 11 masked store |
| base_lo | input | 8 | Fetched low address byte |
| base_hi | input | 8 | Fetched high address byte |
| index | input | 8 | Index register value |
| disp | input | 8 | Signed branch offset |
| pc | input | 16 | Program counter for branches |
| taken | input | 1 | Branch condition is true |
| addr_part | output | 16 | First bus address, high byte uncorrected |
| addr_fix | output | 16 | Corrected final address |
| carry_pend | output | 2 | Pending high-byte adjustment: 00 none, 01 +1, 11 -1 |
| extra_req | output | 1 | A fix-up cycle is in progress |
| hold_next | output | 1 | Hold off the next instruction start |
| done | output | 1 | `addr_fix` became final this cycle |
| st_data | output | 8 | Masked-store data value |

## Verification
The sweeps cover low-byte sums on both sides of 255 and branch offsets in both directions near page edges. A unit that takes carry from the wrong bit would give a wrong high byte or miss the extra cycle. High byte 0xFF checks the wrap to page 0. A design that drops the borrow would send backward page-crossing branches to the wrong page. It would also give them one extra cycle instead of two. Zero-page sums that overflow must stay in page 0, and masked stores must produce an ANDed high byte, not the carried one. A start strobe during the fix-up cycle must not disturb the operation in flight.

// File: rtl/idx_addr_unit.sv
module idx_addr_unit #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      mode,
  input  logic [DW-1:0]   base_lo,
  input  logic [DW-1:0]   base_hi,
  input  logic [DW-1:0]   index,
  input  logic [DW-1:0]   disp,
  input  logic [2*DW-1:0] pc,
  input  logic            taken,
  output logic [2*DW-1:0] addr_part,
  output logic [2*DW-1:0] addr_fix,
  output logic [1:0]      carry_pend,
  output logic            extra_req,
  output logic            hold_next,
  output logic            done,
  output logic [DW-1:0]   st_data
);
  localparam int AW = 2 * DW;

  logic [DW:0]   lo_sum;
  logic [AW-1:0] br_tgt;
  logic          br_cross;
  logic [AW-1:0] n_part;
  logic [DW-1:0] n_hi;
  logic [1:0]    n_cnt, n_carry, cnt;
  logic [DW-1:0] hi_q;
  logic          accept;

  assign lo_sum   = {1'b0, base_lo} + {1'b0, index};
  assign br_tgt   = pc + {{DW{disp[DW-1]}}, disp};
  assign br_cross = br_tgt[AW-1:DW] != pc[AW-1:DW];
  assign accept   = start && (cnt == 2'd0);
  assign extra_req = cnt != 2'd0;

  always_comb begin
    n_part  = {base_hi, lo_sum[DW-1:0]};
    n_hi    = base_hi;
    n_cnt   = 2'd0;
    n_carry = 2'b00;
    case (mode)
      2'b00: begin
        n_hi    = base_hi + {{(DW-1){1'b0}}, lo_sum[DW]};
        n_cnt   = {1'b0, lo_sum[DW]};
        n_carry = {1'b0, lo_sum[DW]};
      end
      2'b01: begin
        n_part = {{DW{1'b0}}, lo_sum[DW-1:0]};
        n_hi   = '0;
      end
      2'b10: begin
        if (taken) begin
          n_part = {pc[AW-1:DW], br_tgt[DW-1:0]};
          n_hi   = br_tgt[AW-1:DW];
          n_cnt  = br_cross ? 2'd2 : 2'd1;
          if (br_cross) n_carry = disp[DW-1] ? 2'b11 : 2'b01;
        end else begin
          n_part = pc;
          n_hi   = pc[AW-1:DW];
        end
      end
      default: begin
        n_hi    = base_hi & index;
        n_cnt   = {1'b0, lo_sum[DW]};
        n_carry = {1'b0, lo_sum[DW]};
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= 2'd0;
      hi_q       <= '0;
      addr_part  <= '0;
      addr_fix   <= '0;
      carry_pend <= 2'b00;
      hold_next  <= 1'b0;
      done       <= 1'b0;
      st_data    <= '0;
    end else if (accept) begin
      cnt        <= n_cnt;
      hi_q       <= n_hi;
      addr_part  <= n_part;
      carry_pend <= n_carry;
      hold_next  <= n_cnt == 2'd2;
      st_data    <= index & (base_hi + {{(DW-1){1'b0}}, 1'b1});
      done       <= n_cnt == 2'd0;
      if (n_cnt == 2'd0) addr_fix <= {n_hi, n_part[DW-1:0]};
    end else if (cnt != 2'd0) begin
      cnt <= cnt - 2'd1;
      if (cnt == 2'd1) begin
        addr_fix   <= {hi_q, addr_part[DW-1:0]};
        carry_pend <= 2'b00;
        hold_next  <= 1'b0;
        done       <= 1'b1;
      end else begin
        done <= 1'b0;
      end
    end else begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/idx_addr_unit_chk.sv
module idx_addr_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [1:0]  mode,
  input logic [15:0] addr_part,
  input logic [1:0]  carry_pend,
  input logic        extra_req,
  input logic        hold_next,
  input logic        done
);
  a_r3_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !extra_req);
  a_r4_zp_page0: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !extra_req && mode == 2'b01) |=> (done && !extra_req && addr_part[15:8] == 8'h00));
  a_r7_hold_in_fix: assert property (@(posedge clk) disable iff (!rst_n)
    hold_next |-> extra_req);
  a_r8_carry_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(extra_req) |-> (carry_pend == 2'b00 && !hold_next && done));
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (extra_req && start) |=> $stable(addr_part));
  a_r2_carry_means_extra: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_pend != 2'b00) |-> extra_req);
endmodule

bind idx_addr_unit idx_addr_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .addr_part(addr_part),
  .carry_pend(carry_pend), .extra_req(extra_req), .hold_next(hold_next), .done(done)
);

// File: tb/idx_addr_unit_tb_top.sv
`timescale 1ns/100ps
module idx_addr_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] base_lo = 8'h00, base_hi = 8'h00, index = 8'h00, disp = 8'h00;
  logic [15:0] pc = 16'h0000;
  logic taken = 1'b0;
  logic [15:0] addr_part, addr_fix;
  logic [1:0] carry_pend;
  logic extra_req, hold_next, done;
  logic [7:0] st_data;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  idx_addr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base_lo(base_lo),
    .base_hi(base_hi), .index(index), .disp(disp), .pc(pc), .taken(taken),
    .addr_part(addr_part), .addr_fix(addr_fix), .carry_pend(carry_pend),
    .extra_req(extra_req), .hold_next(hold_next), .done(done), .st_data(st_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] m, input logic [7:0] lo, input logic [7:0] hi,
                        input logic [7:0] ix, input logic [7:0] d, input logic [15:0] p,
                        input logic tk, input string req);
    logic [8:0] s;
    logic [15:0] tgt, ep, ef;
    logic [1:0] ec;
    int n;
    s = {1'b0, lo} + {1'b0, ix};
    ec = 2'b00;
    n = 0;
    case (m)
      2'b00: begin ep = {hi, s[7:0]}; ef = {hi + {7'd0, s[8]}, s[7:0]}; n = s[8]; ec = {1'b0, s[8]}; end
      2'b01: begin ep = {8'h00, s[7:0]}; ef = ep; end
      2'b10: begin
        tgt = p + {{8{d[7]}}, d};
        if (!tk) begin ep = p; ef = p; end
        else begin
          ep = {p[15:8], tgt[7:0]}; ef = tgt;
          if (tgt[15:8] != p[15:8]) begin n = 2; ec = d[7] ? 2'b11 : 2'b01; end
          else n = 1;
        end
      end
      default: begin ep = {hi, s[7:0]}; ef = {hi & ix, s[7:0]}; n = s[8]; ec = {1'b0, s[8]}; end
    endcase
    @(negedge clk);
    mode = m; base_lo = lo; base_hi = hi; index = ix; disp = d; pc = p; taken = tk; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(addr_part == ep && carry_pend == ec, req, {addr_part, 2'b0, carry_pend}, {ep, 2'b0, ec});
    chk(extra_req == (n > 0) && done == (n == 0) && hold_next == (n == 2), req,
        {extra_req, done, hold_next}, {(n > 0), (n == 0), (n == 2)});
    if (m == 2'b11) chk(st_data == (ix & (hi + 8'd1)), {req, " data"}, st_data, ix & (hi + 8'd1));
    for (int k = n; k >= 1; k--) begin
      @(negedge clk);
      if (k > 1) chk(extra_req && hold_next && !done && addr_part == ep, {req, " wait"},
                     {extra_req, hold_next, done}, 3'b110);
    end
    chk(done && !extra_req && !hold_next && carry_pend == 2'b00, {req, " R8 end"},
        {done, extra_req, hold_next, carry_pend}, 5'b10000);
    chk(addr_fix == ef, {req, " fix"}, addr_fix, ef);
  endtask

  initial begin
    #900000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(addr_part == 0 && addr_fix == 0 && st_data == 0 && carry_pend == 0, "R1 regs",
        {addr_part, addr_fix}, 0);
    chk(!extra_req && !hold_next && !done, "R1 flags", {extra_req, hold_next, done}, 0);
    rst_n = 1'b1;
    // R2 / R3 abs indexed sweep, including high byte FF wrap
    for (int lo = 0; lo < 256; lo += 5)
      for (int ix = 0; ix < 256; ix += 7)
        run_op(2'b00, lo[7:0], (lo[0] ? 8'hFF : lo[7:0] ^ ix[7:0]), ix[7:0], 8'h00, 16'h0, 1'b0, "R2 R3 abs");
    // R4 zero page
    for (int lo = 0; lo < 256; lo += 9)
      for (int ix = 0; ix < 256; ix += 11)
        run_op(2'b01, lo[7:0], 8'h5A, ix[7:0], 8'h00, 16'h0, 1'b0, "R4 zp");
    // R9 masked store
    for (int lo = 0; lo < 256; lo += 13)
      for (int ix = 0; ix < 256; ix += 3)
        run_op(2'b11, lo[7:0], lo[7:0] + ix[7:0] + 8'h37, ix[7:0], 8'h00, 16'h0, 1'b0, "R9 mask");
    // R5 R6 R7 branches
    for (int pl = 0; pl < 256; pl += 3)
      for (int d = 0; d < 256; d += 5) begin
        run_op(2'b10, 8'h00, 8'h00, 8'h00, d[7:0], {pl[7:0] ^ 8'hC3, pl[7:0]}, 1'b1, "R6 R7 br");
        if (d % 25 == 0)
          run_op(2'b10, 8'h00, 8'h00, 8'h00, d[7:0], {8'h80, pl[7:0]}, 1'b0, "R5 br");
      end
    run_op(2'b10, 8'h00, 8'h00, 8'h00, 8'h10, 16'hFFF8, 1'b1, "R7 wrap fwd");
    run_op(2'b10, 8'h00, 8'h00, 8'h00, 8'hF0, 16'h0004, 1'b1, "R7 wrap back");
    // R10 start during fix-up is ignored
    @(negedge clk);
    mode = 2'b00; base_lo = 8'hF0; base_hi = 8'h12; index = 8'h20; start = 1'b1;
    @(negedge clk);
    chk(extra_req && addr_part == 16'h1210, "R10 first", addr_part, 16'h1210);
    base_lo = 8'h01; base_hi = 8'h77; index = 8'h01; mode = 2'b01;
    @(negedge clk);
    start = 1'b0;
    chk(done && addr_part == 16'h1210 && addr_fix == 16'h1310, "R10 ignored", addr_fix, 16'h1310);
    @(negedge clk);
    chk(!done && !extra_req && addr_fix == 16'h1310, "R10 idle", addr_fix, 16'h1310);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule